// File: doc/BRIEF.md
# Two-Stage Tuning Voltage Modulator

This block turns a 13-bit tuning word into one logic-level pulse stream. After an external low-pass filter, the average of that stream is the tuning voltage. The word arrives as two fields. A 6-bit coarse field sets the high time of a pulse-width modulated period. Each period is 64 steps long. A 7-bit fine field then stretches a chosen subset of periods by one extra step. Over any 128 consecutive periods, exactly as many periods are stretched as the fine value. The stretched periods are spread as evenly as possible, so most of the fine-resolution error lands at high frequencies, where the filter removes it easily.

The block runs from a system clock of either of two rates. A rate-select input picks how many clock cycles one step lasts: 2 cycles at the slow rate and 4 at the fast rate. This keeps the period duration the same at both rates. All three control inputs are sampled only in the last cycle of a period. A change made mid-period therefore never cuts a pulse short or adds a runt pulse.

Top module: `tdac_tuning_pwm`

## Requirements
- R1: While reset is asserted, and for the whole first period after reset is released, the output is low. Reset clears the coarse value, the stretch flag and the period index to zero.
- R2: In an unstretched period with coarse value C, the output is high for the first C steps and low for the remaining 64 - C steps. The output is registered, so it shows the state of the previous clock cycle.
- R3: A period is 64 steps. At the slow rate (rate select = 0), one step is 2 clock cycles, which gives 128 cycles per period.
- R4: At the fast rate (rate select = 1), one step is 4 clock cycles, which gives 256 cycles per period. A change of the rate select takes effect only at a period boundary.
- R5: While the fine value F is held constant, any 128 consecutive periods contain exactly F stretched periods.
- R6: A stretched period with coarse value C is high for exactly C + 1 steps.
- R7: The coarse, fine and rate inputs are sampled only in the last clock cycle of a period. A change at any other time has no effect on the period in progress.
- R8: With C = 0 and F = 0, the output stays low constantly.
- R9: With C = 63 and F = 0, every period is high for 63 of its 64 steps.
- R10: With C = 63, a stretched period is high for all 64 steps.
- R11: Periods are indexed modulo 128, and the first period after reset has index 0. A period with index k is stretched exactly when F is greater than the 7-bit bit-reversal of k. For example, with F = 64 the stretched and unstretched periods alternate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_fast_i | input | 1 | Rate select: 0 gives 2 cycles per step, 1 gives 4 cycles per step |
| coarse_i | input | 6 | Coarse field of the tuning word (upper 6 bits) |
| fine_i | input | 7 | Fine field of the tuning word (lower 7 bits) |
| tune_o | output | 1 | Modulated output pulse stream |

## Verification
The bench drives several cases and measures each against an exact count of high cycles:
- **Mid-period coarse change.** The coarse value is changed halfway through a period. A design that latched inputs immediately would lengthen the pulse in that period.
- **Fine value over a full 128-period window.** A wrong comparison direction or a missing bit reversal gives the wrong number of stretched periods, or the wrong way to spread them.
- **Full-scale coarse, with and without stretch.** This exposes a comparator that overflows at 63 + 1: it would give an all-low period where an all-high one is due.
- **Rate change.** A rate select applied immediately would produce a period that is neither 128 nor 256 cycles long.

A behavioural model is compared against the output on every clock cycle, so an off-by-one step boundary is also caught.

// File: rtl/tdac_pkg.sv
// Shared definitions for the two-stage tuning modulator.
// Assumes: the coarse field and the step counter have the same width.
package tdac_pkg;

    // Clock-rate selection as seen by the step timer.
    typedef enum logic {
        RATE_SLOW = 1'b0,
        RATE_FAST = 1'b1
    } tdac_rate_e;

    localparam int unsigned TDAC_COARSE_W = 6;
    localparam int unsigned TDAC_FINE_W   = 7;
    localparam int unsigned TDAC_SLOW_DIV = 2;
    localparam int unsigned TDAC_FAST_DIV = 4;

endpackage

// File: rtl/tdac_step_timer.sv
// Step timer: divides the clock into steps and steps into periods.
// Holds the rate select, reloading it only at a period boundary.
// Assumes: SLOW_DIV and FAST_DIV are both at least 2.
module tdac_step_timer
    import tdac_pkg::*;
#(
    parameter int unsigned STEP_W   = TDAC_COARSE_W,
    parameter int unsigned SLOW_DIV = TDAC_SLOW_DIV,
    parameter int unsigned FAST_DIV = TDAC_FAST_DIV
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rate_fast_i,
    output logic [STEP_W-1:0] step_o,
    output logic              period_end_o
);

    localparam int unsigned MAX_DIV = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
    localparam int unsigned PRESC_W = $clog2(MAX_DIV);
    localparam logic [PRESC_W-1:0] SLOW_LAST = PRESC_W'(SLOW_DIV - 1);
    localparam logic [PRESC_W-1:0] FAST_LAST = PRESC_W'(FAST_DIV - 1);
    localparam logic [STEP_W-1:0]  STEP_LAST = {STEP_W{1'b1}};

    logic [PRESC_W-1:0] presc_q;
    logic [STEP_W-1:0]  step_q;
    tdac_rate_e         rate_q;
    logic [PRESC_W-1:0] div_last;
    logic               tick;
    logic               period_end;

    // Pick the last prescaler count for the active rate.
    always_comb begin
        div_last = (rate_q == RATE_FAST) ? FAST_LAST : SLOW_LAST;
    end

    // Flag the final cycle of a step and of a period.
    always_comb begin
        tick       = (presc_q == div_last);
        period_end = tick && (step_q == STEP_LAST);
    end

    // Advance the prescaler and the step counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_q <= '0;
            step_q  <= '0;
        end else if (tick) begin
            presc_q <= '0;
            step_q  <= step_q + {{(STEP_W-1){1'b0}}, 1'b1};
        end else begin
            presc_q <= presc_q + {{(PRESC_W-1){1'b0}}, 1'b1};
        end
    end

    // Capture the rate select in reset and at each period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || period_end) begin
            rate_q <= tdac_rate_e'(rate_fast_i);
        end
    end

    assign step_o       = step_q;
    assign period_end_o = period_end;

    p_presc_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        presc_q <= div_last);

    p_step_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(step_q));

    p_rate_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !period_end |=> $stable(rate_q));

endmodule

// File: rtl/tdac_fine_seq.sv
// Fine sequencer: keeps the period index and decides, at each boundary,
// whether the coming period is stretched by one step. It does this by
// comparing the fine value against the bit-reversed index of that period.
// Assumes: period_end_i is high for exactly one cycle per period.
module tdac_fine_seq #(
    parameter int unsigned FINE_W = tdac_pkg::TDAC_FINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              period_end_i,
    input  logic [FINE_W-1:0] fine_i,
    output logic              stretch_o
);

    logic [FINE_W-1:0] frame_q;
    logic [FINE_W-1:0] frame_nxt;
    logic [FINE_W-1:0] frame_rev;
    logic              stretch_q;

    // Index of the period about to start.
    always_comb begin
        frame_nxt = frame_q + {{(FINE_W-1){1'b0}}, 1'b1};
    end

    // Mirror the index bits so that consecutive indices scatter evenly.
    for (genvar g = 0; g < FINE_W; g++) begin : g_rev
        assign frame_rev[g] = frame_nxt[FINE_W-1-g];
    end

    // Step the period index and latch the stretch decision at a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q   <= '0;
            stretch_q <= 1'b0;
        end else if (period_end_i) begin
            frame_q   <= frame_nxt;
            stretch_q <= (fine_i > frame_rev);
        end
    end

    assign stretch_o = stretch_q;

    p_frame_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        period_end_i |=> frame_q == FINE_W'($past(frame_q) + 1));

    p_stretch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !period_end_i |=> ($stable(stretch_q) && $stable(frame_q)));

endmodule

// File: rtl/tdac_pwm_core.sv
// Coarse modulator: holds the coarse value for a whole period and
// drives a registered output that is high while step < coarse + stretch.
// Assumes: the step counter wraps at 2**STEP_W.
module tdac_pwm_core #(
    parameter int unsigned STEP_W = tdac_pkg::TDAC_COARSE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STEP_W-1:0] step_i,
    input  logic              period_end_i,
    input  logic [STEP_W-1:0] coarse_i,
    input  logic              stretch_i,
    output logic              pwm_o
);

    localparam logic [STEP_W-1:0] STEP_LAST = {STEP_W{1'b1}};

    logic [STEP_W-1:0] coarse_q;
    logic [STEP_W:0]   width;
    logic              high_d;
    logic              pwm_q;

    // Latch the coarse value only at a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coarse_q <= '0;
        end else if (period_end_i) begin
            coarse_q <= coarse_i;
        end
    end

    // Width in steps, one bit wider so that 63 + 1 does not wrap.
    always_comb begin
        width  = {1'b0, coarse_q} + {{STEP_W{1'b0}}, stretch_i};
        high_d = ({1'b0, step_i} < width);
    end

    // Register the output so it carries no comparator glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_q <= 1'b0;
        end else begin
            pwm_q <= high_d;
        end
    end

    assign pwm_o = pwm_q;

    p_coarse_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !period_end_i |=> $stable(coarse_q));

    p_zero_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (coarse_q == '0 && !stretch_i) |=> !pwm_o);

    p_first_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i == '0 && (coarse_q != '0 || stretch_i)) |=> pwm_o);

    p_top_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i == STEP_LAST && !stretch_i) |=> !pwm_o);

    p_full_period_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (coarse_q == STEP_LAST && stretch_i) |=> pwm_o);

endmodule

// File: rtl/tdac_tuning_pwm.sv
// Two-stage tuning modulator top. The coarse field sets the high time of
// a 64-step period. The fine field stretches selected periods by one step.
// Assumes: inputs are synchronous to clk. All of them are sampled only at
// a period boundary.
module tdac_tuning_pwm
    import tdac_pkg::*;
#(
    parameter int unsigned COARSE_W = TDAC_COARSE_W,
    parameter int unsigned FINE_W   = TDAC_FINE_W,
    parameter int unsigned SLOW_DIV = TDAC_SLOW_DIV,
    parameter int unsigned FAST_DIV = TDAC_FAST_DIV
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rate_fast_i,
    input  logic [COARSE_W-1:0] coarse_i,
    input  logic [FINE_W-1:0]   fine_i,
    output logic                tune_o
);

    logic [COARSE_W-1:0] step;
    logic                period_end;
    logic                stretch;

    tdac_step_timer #(
        .STEP_W   (COARSE_W),
        .SLOW_DIV (SLOW_DIV),
        .FAST_DIV (FAST_DIV)
    ) i_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .rate_fast_i  (rate_fast_i),
        .step_o       (step),
        .period_end_o (period_end)
    );

    tdac_fine_seq #(
        .FINE_W (FINE_W)
    ) i_fine (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_end_i (period_end),
        .fine_i       (fine_i),
        .stretch_o    (stretch)
    );

    tdac_pwm_core #(
        .STEP_W (COARSE_W)
    ) i_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_i       (step),
        .period_end_i (period_end),
        .coarse_i     (coarse_i),
        .stretch_i    (stretch),
        .pwm_o        (tune_o)
    );

endmodule

// File: tb/test_tdac_tuning_pwm.sv
`timescale 1ns/1ps
module test_tdac_tuning_pwm;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rate_fast = 1'b0;
    logic [5:0] coarse = 6'd20;
    logic [6:0] fine = 7'd0;
    logic       tune;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    // Reference model state
    int m_pos = 0, m_div = 2, m_frame = 0, m_coarse = 0, m_fine = 0;
    int m_stretch = 0, m_out = 0;

    always #2 clk = ~clk;

    tdac_tuning_pwm i_tdac_tuning_pwm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rate_fast_i (rate_fast),
        .coarse_i    (coarse),
        .fine_i      (fine),
        .tune_o      (tune)
    );

    function automatic int rev7(input int v);
        int r = 0;
        for (int i = 0; i < 7; i++) if ((v >> i) & 1) r |= (1 << (6 - i));
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Behavioural reference: position counted in cycles within a period.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos = 0; m_frame = 0; m_coarse = 0; m_fine = 0;
            m_stretch = 0; m_out = 0;
            m_div = rate_fast ? 4 : 2;
        end else begin
            m_out = ((m_pos / m_div) < (m_coarse + m_stretch)) ? 1 : 0;
            if (m_pos == 64 * m_div - 1) begin
                m_pos = 0;
                m_frame = (m_frame + 1) % 128;
                m_coarse = coarse;
                m_fine = fine;
                m_div = rate_fast ? 4 : 2;
                m_stretch = (m_fine > rev7(m_frame)) ? 1 : 0;
            end else begin
                m_pos = m_pos + 1;
            end
        end
    end

    // Compare output with the model on every cycle (R2 R6 R11 timing).
    always @(negedge clk) begin
        if (!done) check(tune == m_out[0], "R2 R6 R11 per-cycle model", tune, m_out);
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    task automatic wait_pos(input int p);
        do @(negedge clk); while (m_pos != p);
    endtask

    task automatic count_high(input int cycles, output int highs);
        highs = 0;
        for (int i = 0; i < cycles; i++) begin
            if (i > 0) @(negedge clk);
            highs += tune;
        end
    endtask

    task automatic measure_period(output int n);
        n = 0;
        do @(negedge clk); while (!(tune === 1'b0));
        do @(negedge clk); while (!(tune === 1'b1));
        do begin @(negedge clk); n++; end while (!(tune === 1'b0));
        do begin @(negedge clk); n++; end while (!(tune === 1'b1));
    endtask

    initial begin
        int h, p, stretched, full, prev;
        repeat (5) @(negedge clk);
        check(tune == 1'b0, "R1 low during reset", tune, 0);
        rst_n = 1'b1;
        @(negedge clk);
        count_high(128, h);
        check(h == 0, "R1 first period low", h, 0);

        wait_pos(1); count_high(128, h);
        check(h == 40, "R2 coarse 20 high cycles", h, 40);
        measure_period(p);
        check(p == 128, "R3 slow period length", p, 128);

        wait_pos(10); coarse = 6'd40;
        wait_pos(51);
        check(tune == 1'b0, "R7 mid-period change ignored", tune, 0);
        wait_pos(1); count_high(128, h);
        check(h == 80, "R7 new coarse after boundary", h, 80);

        coarse = 6'd63;
        wait_pos(0); wait_pos(1); count_high(128, h);
        check(h == 126, "R9 63 of 64 steps", h, 126);

        coarse = 6'd0;
        wait_pos(0); wait_pos(1); count_high(256, h);
        check(h == 0, "R8 zero gives constant low", h, 0);

        rate_fast = 1'b1; coarse = 6'd20;
        wait_pos(0); wait_pos(1); count_high(256, h);
        check(h == 80, "R4 fast rate high cycles", h, 80);
        measure_period(p);
        check(p == 256, "R4 fast period length", p, 256);

        rate_fast = 1'b0; coarse = 6'd10; fine = 7'd5;
        wait_pos(0); wait_pos(1);
        stretched = 0;
        for (int k = 0; k < 128; k++) begin
            if (k > 0) wait_pos(1);
            count_high(128, h);
            check(h == 20 || h == 22, "R6 period width C or C+1", h, 22);
            if (h == 22) stretched++;
        end
        check(stretched == 5, "R5 stretched count in 128", stretched, 5);

        rate_fast = 1'b1; coarse = 6'd3; fine = 7'd64;
        wait_pos(0); wait_pos(1); count_high(256, prev);
        for (int k = 0; k < 15; k++) begin
            wait_pos(1); count_high(256, h);
            check(h != prev, "R11 alternation for fine 64", h, (prev == 12) ? 16 : 12);
            prev = h;
        end

        rate_fast = 1'b0; coarse = 6'd63; fine = 7'd127;
        wait_pos(0); wait_pos(1);
        full = 0;
        for (int k = 0; k < 128; k++) begin
            if (k > 0) wait_pos(1);
            count_high(128, h);
            if (h == 128) full++;
        end
        check(full == 127, "R10 full-high periods", full, 127);

        done = 1;
        summary();
        $finish;
    end

endmodule